// File: doc/BRIEF.md
# Conditional Branch and Return-Stack Unit

This block owns the program counter of a small 8-bit processor and the hardware stack of return addresses. Each cycle a decoder may present one instruction with the strobe `dec_valid`. The strobe comes with four things:

- the instruction kind;
- whether the instruction is conditional;
- a 3-bit condition code;
- a target address and the instruction length in bytes.

The unit tests the condition code against the carry, zero, sign and parity flags. It then does one of four things: jumps, calls (pushing the return address), returns (popping it), or steps past the instruction.

The return stack holds eight 13-bit entries and works as a ring. Pushing onto a full stack drops the oldest entry and sets a sticky overflow flag. A taken return on an empty stack sets a sticky underflow flag and leaves the program counter where it is. Only reset clears the two flags.

Top module: `flow_ctl_unit`

## Requirements
- R1: After reset `pc` is 0 and both `stack_ovf` and `stack_udf` are 0.
- R2: A strobed instruction of kind 0 (step) sets `pc` to `pc + dec_len`.
- R3: Bits 1:0 of `dec_cond` choose the flag: 0 carry, 1 zero, 2 sign, 3 parity (`flag_p` is 1 for even parity). A conditional instruction is taken when the chosen flag equals bit 2 of `dec_cond`.
- R4: A jump (kind 1) loads `dec_target` into `pc` when taken. When not taken it sets `pc` to `pc + dec_len`.
- R5: A taken call (kind 2) pushes `pc + dec_len` and loads `dec_target` into `pc`.
- R6: A taken return (kind 3) on a non-empty stack loads the most recently pushed address into `pc`. Nested calls unwind in last-in, first-out order.
- R7: A call or return that is not taken leaves the stack contents unchanged and sets `pc` to `pc + dec_len`.
- R8: A taken call while eight entries are held sets `stack_ovf`, which stays set until reset. The oldest entry is lost and the eight newest entries remain poppable.
- R9: A taken return on an empty stack sets `stack_udf`, which stays set until reset, and leaves `pc` unchanged.
- R10: With `dec_valid` low, `pc` and the stack hold their values.
- R11: All additions to `pc` wrap modulo 2^13.
- R12: With `dec_cond_en` low, jumps, calls and returns are taken whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is present this cycle |
| dec_kind | input | 2 | 0 step, 1 jump, 2 call, 3 return |
| dec_cond_en | input | 1 | Instruction is conditional |
| dec_cond | input | 3 | Bit 2 sense, bits 1:0 flag select |
| dec_target | input | 13 | Jump or call target address |
| dec_len | input | 2 | Instruction length in bytes |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_p | input | 1 | Parity flag, 1 means even |
| pc | output | 13 | Program counter |
| stack_ovf | output | 1 | Sticky stack overflow |
| stack_udf | output | 1 | Sticky stack underflow |

## Verification
Every result is registered once. The new `pc`, a push or pop, and any change to the sticky flags become visible on the first rising edge after the strobed cycle. The bench drives each instruction just after a falling edge and holds it through one rising edge. It removes the strobe and compares outputs at the following falling edge, so every comparison falls exactly one edge after its stimulus. The condition logic is swept over all eight codes and all sixteen flag patterns, for both jumps and calls. A stack model in the bench supplies the expected return addresses through overflow and underflow.

// File: rtl/flow_ctl_unit.sv
module flow_ctl_unit #(
  parameter int AW  = 13,
  parameter int SDW = 3,
  parameter int LW  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  input  logic [1:0]    dec_kind,
  input  logic          dec_cond_en,
  input  logic [2:0]    dec_cond,
  input  logic [AW-1:0] dec_target,
  input  logic [LW-1:0] dec_len,
  input  logic          flag_c,
  input  logic          flag_z,
  input  logic          flag_s,
  input  logic          flag_p,
  output logic [AW-1:0] pc,
  output logic          stack_ovf,
  output logic          stack_udf
);
  localparam int DEPTH = 1 << SDW;
  localparam logic [1:0] K_STEP = 2'd0, K_JMP = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  logic [AW-1:0]  stk [DEPTH];
  logic [SDW-1:0] sp;
  logic [SDW:0]   cnt;

  wire [3:0]     flags   = {flag_p, flag_s, flag_z, flag_c};
  wire           take    = !dec_cond_en || (flags[dec_cond[1:0]] == dec_cond[2]);
  wire [AW-1:0]  seq_pc  = pc + AW'(dec_len);
  wire           empty   = (cnt == '0);
  wire           full    = (cnt == (SDW+1)'(DEPTH));
  wire           do_push = dec_valid && dec_kind == K_CALL && take;
  wire           do_pop  = dec_valid && dec_kind == K_RET && take && !empty;
  wire           do_udf  = dec_valid && dec_kind == K_RET && take && empty;
  wire [SDW-1:0] top     = sp - SDW'(1);

  always_ff @(posedge clk)
    if (do_push) stk[sp] <= seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      sp        <= '0;
      cnt       <= '0;
      stack_ovf <= 1'b0;
      stack_udf <= 1'b0;
    end else if (dec_valid) begin
      unique case (dec_kind)
        K_STEP: pc <= seq_pc;
        K_JMP:  pc <= take ? dec_target : seq_pc;
        K_CALL: begin
          pc <= take ? dec_target : seq_pc;
          if (do_push) begin
            sp <= sp + SDW'(1);
            if (full) stack_ovf <= 1'b1;
            else      cnt <= cnt + 1'b1;
          end
        end
        K_RET: begin
          if (!take) pc <= seq_pc;
          else if (do_pop) begin
            pc  <= stk[top];
            sp  <= top;
            cnt <= cnt - 1'b1;
          end else if (do_udf) stack_udf <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/flow_ctl_unit_chk.sv
module flow_ctl_unit_chk #(
  parameter int AW  = 13,
  parameter int SDW = 3,
  parameter int LW  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dec_valid,
  input logic [1:0]    dec_kind,
  input logic          dec_cond_en,
  input logic [AW-1:0] dec_target,
  input logic [LW-1:0] dec_len,
  input logic [AW-1:0] pc,
  input logic          stack_ovf,
  input logic          stack_udf,
  input logic [SDW:0]  cnt
);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> $stable(pc));
  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_kind == 2'd0 |=> pc == $past(pc) + AW'($past(dec_len)));
  // R12
  uncond_jmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && (dec_kind == 2'd1 || dec_kind == 2'd2) && !dec_cond_en |=> pc == $past(dec_target));
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_kind == 2'd2 && !dec_cond_en && cnt == (SDW+1)'(1 << SDW) |=> stack_ovf);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_ovf |=> stack_ovf);
  // R9
  udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_udf |=> stack_udf);
  // R9
  udf_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stack_udf) |-> $stable(pc));
  // R9
  udf_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stack_udf) |-> $past(cnt) == '0);
endmodule

bind flow_ctl_unit flow_ctl_unit_chk #(.AW(AW), .SDW(SDW), .LW(LW)) u_chk (.*);

// File: tb/flow_ctl_unit_tb.sv
module flow_ctl_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_valid = 1'b0;
  logic [1:0]  dec_kind = '0;
  logic        dec_cond_en = 1'b0;
  logic [2:0]  dec_cond = '0;
  logic [12:0] dec_target = '0;
  logic [1:0]  dec_len = '0;
  logic        flag_c = 1'b0, flag_z = 1'b0, flag_s = 1'b0, flag_p = 1'b0;
  logic [12:0] pc;
  logic        stack_ovf, stack_udf;

  int n_chk = 0, n_fail = 0;
  logic [12:0] mpc;
  logic [12:0] mstk [8];
  int mcnt;
  logic movf, mudf;

  flow_ctl_unit u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; dec_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    mpc = '0; mcnt = 0; movf = 1'b0; mudf = 1'b0;
  endtask

  task automatic op(input logic [1:0] k, input logic ce, input logic [2:0] c,
                    input logic [12:0] t, input logic [1:0] l, input logic [3:0] f);
    logic tk;
    logic [12:0] nxt;
    tk  = !ce || (f[c[1:0]] == c[2]);
    nxt = 13'((32'(mpc) + 32'(l)) % 8192);
    case (k)
      2'd0: mpc = nxt;
      2'd1: mpc = tk ? t : nxt;
      2'd2: begin
        if (tk) begin
          if (mcnt == 8) begin
            for (int i = 0; i < 7; i++) mstk[i] = mstk[i+1];
            mstk[7] = nxt; movf = 1'b1;
          end else begin
            mstk[mcnt] = nxt; mcnt++;
          end
          mpc = t;
        end else mpc = nxt;
      end
      default: begin
        if (!tk) mpc = nxt;
        else if (mcnt == 0) mudf = 1'b1;
        else begin mcnt--; mpc = mstk[mcnt]; end
      end
    endcase
    @(negedge clk);
    dec_valid = 1'b1; dec_kind = k; dec_cond_en = ce; dec_cond = c;
    dec_target = t; dec_len = l;
    {flag_p, flag_s, flag_z, flag_c} = f;
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1", pc, 0); chk("R1", stack_ovf, 0); chk("R1", stack_udf, 0);

    repeat (3) @(negedge clk);
    chk("R10", pc, 0);

    for (int l = 0; l < 4; l++) begin
      op(2'd0, 1'b0, 3'd0, 13'h0, 2'(l), 4'h0);
      chk("R2", pc, mpc);
    end

    op(2'd1, 1'b0, 3'd0, 13'h1FFF, 2'd1, 4'h0); chk("R12", pc, 13'h1FFF);
    op(2'd0, 1'b0, 3'd0, 13'h0, 2'd2, 4'h0);    chk("R11", pc, 13'h0001);
    op(2'd1, 1'b0, 3'd0, 13'h1FFE, 2'd1, 4'h0);
    op(2'd1, 1'b1, 3'd0, 13'h0, 2'd3, 4'h1);    chk("R11", pc, 13'h0001);

    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++) begin
        op(2'd1, 1'b0, 3'd0, 13'h0100, 2'd3, 4'h0);
        op(2'd1, 1'b1, 3'(c), 13'(13'h0A00 + 13'(c * 16 + f)), 2'd3, 4'(f));
        chk("R3/R4 jump", pc, mpc);
      end

    for (int f = 0; f < 16; f++) begin
      op(2'd1, 1'b0, 3'(f & 7), 13'h0777, 2'd3, 4'(f)); chk("R12 jump", pc, 13'h0777);
    end

    do_reset();
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++) begin
        op(2'd1, 1'b0, 3'd0, 13'h0200, 2'd3, 4'h0);
        op(2'd2, 1'b1, 3'(c), 13'h0400, 2'd3, 4'(f));
        chk("R3/R5 call", pc, mpc);
        op(2'd3, 1'b1, 3'(c), 13'h0, 2'd1, 4'(f));
        chk("R3/R6/R7 ret", pc, mpc);
      end
    chk("R7", stack_udf, 0);

    do_reset();
    op(2'd2, 1'b0, 3'd0, 13'h0100, 2'd3, 4'h0);
    op(2'd2, 1'b0, 3'd0, 13'h0200, 2'd3, 4'h0);
    op(2'd2, 1'b0, 3'd0, 13'h0300, 2'd3, 4'h0);
    op(2'd2, 1'b1, 3'd4, 13'h0900, 2'd3, 4'h0); chk("R7 call not taken", pc, 13'h0303);
    op(2'd3, 1'b1, 3'd5, 13'h0, 2'd1, 4'h0);    chk("R7 ret not taken", pc, 13'h0304);
    op(2'd3, 1'b0, 3'd0, 13'h0, 2'd1, 4'h0);    chk("R6", pc, 13'h0203);
    op(2'd3, 1'b0, 3'd0, 13'h0, 2'd1, 4'h0);    chk("R6", pc, 13'h0103);
    op(2'd3, 1'b0, 3'd0, 13'h0, 2'd1, 4'h0);    chk("R6", pc, 13'h0003);
    op(2'd3, 1'b0, 3'd0, 13'h0, 2'd1, 4'h0);    chk("R9", pc, 13'h0003);
    chk("R9", stack_udf, 1);
    chk("R9", stack_ovf, 0);
    op(2'd0, 1'b0, 3'd0, 13'h0, 2'd1, 4'h0);    chk("R9 sticky", stack_udf, 1);

    do_reset();
    for (int i = 0; i < 9; i++) begin
      op(2'd2, 1'b0, 3'd0, 13'(13'h0040 * (i + 1)), 2'd3, 4'h0);
      chk("R8", stack_ovf, (i == 8) ? 1 : 0);
    end
    for (int i = 0; i < 8; i++) begin
      op(2'd3, 1'b0, 3'd0, 13'h0, 2'd1, 4'h0);
      chk("R8 pop", pc, mpc);
    end
    chk("R8 sticky", stack_ovf, 1);
    chk("R8", stack_udf, 0);
    op(2'd3, 1'b0, 3'd0, 13'h0, 2'd1, 4'h0);
    chk("R9", stack_udf, 1); chk("R9", pc, mpc);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule